// File: doc/BRIEF.md
# Chained 2D DMA Transfer Engine

This block is one channel of a memory-to-memory copy engine that follows a linked list of descriptors held in memory. A pulse on the start input, while the channel is enabled, loads a first descriptor address. For each descriptor the engine reads six words from memory, then moves 32-bit words from a source to a destination. A descriptor with a zero next pointer ends the chain. So does a channel that is disabled when the engine is between descriptors.

A descriptor describes either one linear row or a rectangle of rows. In the rectangle case the row count and the row byte length are packed into the length word. Signed row strides for the source and the destination are packed into the stride word, and they are added to both addresses between rows. Per-descriptor flags choose whether each address advances after a beat, whether reads are replaced by zero data (fill), and whether writes are dropped (a read-only sweep). When a descriptor finishes, the engine sets a completion flag and may raise its interrupt. When the chain ends, the engine reports itself paused.

All memory traffic uses one word-wide request port. A request is held until it is accepted, read data returns on a separate valid strobe, and only one access is in flight at any time. Writes are posted: a write is complete once it is accepted.

Top module: `dma_chain_engine`

## Requirements
- R1: A descriptor is six 32-bit words read at byte offsets 0, 4, 8, 12, 16 and 20 from its address. In that order they hold the flags word, the source address, the destination address, the length word, the stride word and the next-descriptor address.
- R2: The engine processes descriptors while `chan_en` is high and the current descriptor address is nonzero. It checks both before each fetch. A start with address 0 ends at once, with no memory access.
- R3: With flags bit 1 set (2D mode), the row count is length bits [29:16] plus one and the row byte length is length bits [15:0]. The destination stride is stride bits [31:16] and the source stride is stride bits [15:0], both signed.
- R4: With flags bit 1 clear, the whole 32-bit length word is the byte count of a single row and no stride is applied.
- R5: Each beat moves one word. The source address grows by 4 after a beat only when flags bit 8 is set. The destination address grows by 4 only when flags bit 4 is set.
- R6: With flags bit 11 set, no read is issued and zero is written. With flags bit 7 set, no write is issued.
- R7: `xfer_len` drops by 4 after each beat. In 2D mode it reads (rows remaining << 16) | bytes left in the row. After the final beat of a descriptor it is 0 in linear mode and 0x00010000 in 2D mode.
- R8: After every row except the last, the signed strides are added to the source and destination addresses and the row byte count is reloaded.
- R9: When a descriptor completes, status bit 1 (END) is set. If flags bit 0 is set, status bit 2 (INT) is also set and `irq` goes high. The next-descriptor address then becomes `cur_desc`.
- R10: When the chain ends, status bit 0 (ACTIVE) clears and status bit 4 (PAUSED) sets. ACTIVE and PAUSED are never high together.
- R11: At most one memory access is outstanding. A request is held with the same address and direction until it is accepted, and no request is issued while read data is awaited.
- R12: A row byte length of zero finishes the row with no read or write beat.
- R13: `start` is ignored unless `chan_en` is high and the engine is idle. An accepted start sets ACTIVE and clears END, INT and PAUSED, which also drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable, sampled before each descriptor |
| start | input | 1 | One-cycle pulse that begins a chain |
| start_addr | input | ADDR_W | Address of the first descriptor |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| status | output | 5 | Bit 0 ACTIVE, bit 1 END, bit 2 INT, bit 3 zero, bit 4 PAUSED |
| irq | output | 1 | Channel interrupt, follows INT |
| xfer_len | output | 32 | Remaining length as described in R7 |
| cur_desc | output | ADDR_W | Current descriptor address |

## Verification
The copy path is tried with a linear block copy and with a two-row rectangle that uses a positive source stride and a negative destination stride. Comparing the words at their exact landing addresses separates correct stride signs and row reloads from an off-by-one row count. A two-descriptor chain ending in a zero-fill descriptor, a pass with both address increments off, and a read-only pass with writes suppressed tell the increment and ignore flags apart. For these passes the bench also counts read and write requests. Zero-length rows, a start at address 0, a start with the channel disabled, and a channel disabled in mid-chain cover the paths where the engine ends early. In those cases the number of memory requests and the untouched destination words are what show that the engine stopped.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
   localparam int DESC_WORDS = 6;
   localparam int WORD_W     = 32;
   localparam int ROWF_W     = 14;   // row count field width in 2D length word
   localparam int XF_W       = 16;   // row byte length field width in 2D mode
   localparam int STR_W      = 16;   // each signed stride field

   // flag word bit positions
   localparam int FB_INT_EN = 0;
   localparam int FB_2D     = 1;
   localparam int FB_D_INC  = 4;
   localparam int FB_D_SKIP = 7;
   localparam int FB_S_INC  = 8;
   localparam int FB_S_ZERO = 11;

   // descriptor word slots
   localparam int DW_FLAGS  = 0;
   localparam int DW_SRC    = 1;
   localparam int DW_DST    = 2;
   localparam int DW_LEN    = 3;
   localparam int DW_STRIDE = 4;
   localparam int DW_NEXT   = 5;

   typedef enum logic [3:0] {
      CS_IDLE, CS_CHECK, CS_FREQ, CS_FWAIT, CS_SETUP, CS_BEAT,
      CS_RREQ, CS_RWAIT, CS_WREQ, CS_ADV, CS_ROW, CS_DONE
   } ctl_state_t;
endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs #(
   parameter int WORDS = 6,
   parameter int IDX_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      words [WORDS]
);
   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            q <= '0;
         else if (cap && (idx == IDX_W'(i)))    q <= wdata;
      end
      assign words[i] = q;
   end
endmodule

// File: rtl/dma_walk.sv
module dma_walk
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = ROWF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              two_d,
   input  logic [31:0]       len_word,
   input  logic [31:0]       stride_word,
   input  logic [ADDR_W-1:0] src_init,
   input  logic [ADDR_W-1:0] dst_init,
   input  logic              s_inc,
   input  logic              d_inc,
   input  logic              step,
   input  logic              row_next,
   output logic [ADDR_W-1:0] src,
   output logic [ADDR_W-1:0] dst,
   output logic [31:0]       vis_len,
   output logic              row_empty,
   output logic              last_row
);
   logic [ADDR_W-1:0] src_q, dst_q, sstr_q, dstr_q, sstr_x, dstr_x;
   logic [31:0]       xrem_q, xrow_q;
   logic [CNT_W-1:0]  rows_q;
   logic              mode2d_q;

   if (ADDR_W > STR_W) begin : g_sext
      assign sstr_x = {{(ADDR_W-STR_W){stride_word[STR_W-1]}}, stride_word[STR_W-1:0]};
      assign dstr_x = {{(ADDR_W-STR_W){stride_word[31]}}, stride_word[31:STR_W]};
   end else begin : g_trunc
      assign sstr_x = stride_word[ADDR_W-1:0];
      assign dstr_x = stride_word[STR_W +: ADDR_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0; dst_q <= '0; sstr_q <= '0; dstr_q <= '0;
         xrem_q <= '0; xrow_q <= '0; rows_q <= '0; mode2d_q <= 1'b0;
      end else if (load) begin
         src_q    <= src_init;
         dst_q    <= dst_init;
         mode2d_q <= two_d;
         if (two_d) begin
            rows_q <= CNT_W'(len_word[XF_W +: ROWF_W]) + CNT_W'(1);
            xrow_q <= 32'(len_word[XF_W-1:0]);
            xrem_q <= 32'(len_word[XF_W-1:0]);
            sstr_q <= sstr_x;
            dstr_q <= dstr_x;
         end else begin
            rows_q <= CNT_W'(1);
            xrow_q <= len_word;
            xrem_q <= len_word;
            sstr_q <= '0;
            dstr_q <= '0;
         end
      end else if (step) begin
         src_q  <= src_q + (s_inc ? ADDR_W'(4) : '0);
         dst_q  <= dst_q + (d_inc ? ADDR_W'(4) : '0);
         xrem_q <= xrem_q - 32'd4;
      end else if (row_next) begin
         src_q  <= src_q + sstr_q;
         dst_q  <= dst_q + dstr_q;
         xrem_q <= xrow_q;
         rows_q <= rows_q - CNT_W'(1);
      end
   end

   assign src       = src_q;
   assign dst       = dst_q;
   assign row_empty = (xrem_q == '0);
   assign last_row  = (rows_q <= CNT_W'(1));
   assign vis_len   = mode2d_q ? {{(XF_W-CNT_W){1'b0}}, rows_q, xrem_q[XF_W-1:0]} : xrem_q;
endmodule

// File: rtl/dma_flags.sv
module dma_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_start,
   input  logic       desc_done,
   input  logic       int_en,
   input  logic       chain_end,
   output logic [4:0] status,
   output logic       irq
);
   logic active_q, end_q, int_q, paused_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0; end_q <= 1'b0; int_q <= 1'b0; paused_q <= 1'b0;
      end else if (run_start) begin
         active_q <= 1'b1; end_q <= 1'b0; int_q <= 1'b0; paused_q <= 1'b0;
      end else begin
         if (desc_done) begin
            end_q <= 1'b1;
            if (int_en) int_q <= 1'b1;
         end
         if (chain_end) begin
            active_q <= 1'b0;
            paused_q <= 1'b1;
         end
      end
   end

   assign status = {paused_q, 1'b0, int_q, end_q, active_q};
   assign irq    = int_q;
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = $clog2(DESC_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [31:0]       mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_rdata,
   output logic [4:0]        status,
   output logic              irq,
   output logic [31:0]       xfer_len,
   output logic [ADDR_W-1:0] cur_desc
);
   if (ADDR_W < 8 || ADDR_W > WORD_W) begin : g_bad_addr_w
      $error("dma_chain_engine: ADDR_W must lie in 8..32");
   end

   ctl_state_t        st_q, st_d;
   logic [IDX_W-1:0]  widx_q;
   logic [ADDR_W-1:0] desc_q;
   logic [31:0]       data_q;
   logic [31:0]       dw [DESC_WORDS];
   logic [31:0]       flags;
   logic [ADDR_W-1:0] w_src, w_dst;
   logic              row_empty, last_row;
   logic              run_start, desc_done, chain_end, cap, w_load, w_step, w_row_next;

   assign flags = dw[DW_FLAGS];

   dma_desc_regs #(.WORDS(DESC_WORDS), .IDX_W(IDX_W)) u_desc (
      .clk(clk), .rst_n(rst_n), .cap(cap), .idx(widx_q),
      .wdata(mem_rsp_rdata), .words(dw)
   );

   dma_walk #(.ADDR_W(ADDR_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(w_load), .two_d(flags[FB_2D]),
      .len_word(dw[DW_LEN]), .stride_word(dw[DW_STRIDE]),
      .src_init(dw[DW_SRC][ADDR_W-1:0]), .dst_init(dw[DW_DST][ADDR_W-1:0]),
      .s_inc(flags[FB_S_INC]), .d_inc(flags[FB_D_INC]),
      .step(w_step), .row_next(w_row_next),
      .src(w_src), .dst(w_dst), .vis_len(xfer_len),
      .row_empty(row_empty), .last_row(last_row)
   );

   dma_flags u_flags (
      .clk(clk), .rst_n(rst_n), .run_start(run_start), .desc_done(desc_done),
      .int_en(flags[FB_INT_EN]), .chain_end(chain_end),
      .status(status), .irq(irq)
   );

   always_comb begin
      st_d       = st_q;
      run_start  = 1'b0;
      desc_done  = 1'b0;
      chain_end  = 1'b0;
      cap        = 1'b0;
      w_load     = 1'b0;
      w_step     = 1'b0;
      w_row_next = 1'b0;
      unique case (st_q)
         CS_IDLE:  if (start && chan_en) begin run_start = 1'b1; st_d = CS_CHECK; end
         CS_CHECK: if (!chan_en || desc_q == '0) begin chain_end = 1'b1; st_d = CS_IDLE; end
                   else st_d = CS_FREQ;
         CS_FREQ:  if (mem_req_ready) st_d = CS_FWAIT;
         CS_FWAIT: if (mem_rsp_valid) begin
                      cap  = 1'b1;
                      st_d = (widx_q == IDX_W'(DESC_WORDS-1)) ? CS_SETUP : CS_FREQ;
                   end
         CS_SETUP: begin w_load = 1'b1; st_d = CS_BEAT; end
         CS_BEAT:  if (row_empty)              st_d = CS_ROW;
                   else if (!flags[FB_S_ZERO]) st_d = CS_RREQ;
                   else                        st_d = flags[FB_D_SKIP] ? CS_ADV : CS_WREQ;
         CS_RREQ:  if (mem_req_ready) st_d = CS_RWAIT;
         CS_RWAIT: if (mem_rsp_valid) st_d = flags[FB_D_SKIP] ? CS_ADV : CS_WREQ;
         CS_WREQ:  if (mem_req_ready) st_d = CS_ADV;
         CS_ADV:   begin w_step = 1'b1; st_d = CS_BEAT; end
         CS_ROW:   if (!last_row) begin w_row_next = 1'b1; st_d = CS_BEAT; end
                   else st_d = CS_DONE;
         CS_DONE:  begin desc_done = 1'b1; st_d = CS_CHECK; end
         default:  st_d = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CS_IDLE;
         widx_q <= '0;
         desc_q <= '0;
         data_q <= '0;
      end else begin
         st_q <= st_d;
         if (run_start) desc_q <= start_addr;
         if (desc_done) desc_q <= dw[DW_NEXT][ADDR_W-1:0];
         if (st_q == CS_CHECK) widx_q <= '0;
         else if (cap)         widx_q <= widx_q + IDX_W'(1);
         if (st_q == CS_BEAT && flags[FB_S_ZERO]) data_q <= '0;
         else if (st_q == CS_RWAIT && mem_rsp_valid) data_q <= mem_rsp_rdata;
      end
   end

   always_comb begin
      mem_req_valid = 1'b0;
      mem_req_write = 1'b0;
      mem_req_addr  = '0;
      mem_req_wdata = data_q;
      case (st_q)
         CS_FREQ: begin mem_req_valid = 1'b1; mem_req_addr = desc_q + ADDR_W'({widx_q, 2'b00}); end
         CS_RREQ: begin mem_req_valid = 1'b1; mem_req_addr = w_src; end
         CS_WREQ: begin mem_req_valid = 1'b1; mem_req_write = 1'b1; mem_req_addr = w_dst; end
         default: ;
      endcase
   end

   assign cur_desc = desc_q;
endmodule

// File: rtl/dma_chain_engine_chk.sv
module dma_chain_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chan_en,
   input logic              start,
   input logic [ADDR_W-1:0] start_addr,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [31:0]       mem_req_wdata,
   input logic              mem_rsp_valid,
   input logic [31:0]       mem_rsp_rdata,
   input logic [4:0]        status,
   input logic              irq,
   input logic [31:0]       xfer_len,
   input logic [ADDR_W-1:0] cur_desc
);
   logic rd_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_pend <= 1'b0;
      else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pend <= 1'b1;
      else if (mem_rsp_valid) rd_pend <= 1'b0;
   end

   a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

   a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pend |-> !mem_req_valid);

   a_r11_no_stray_data: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> rd_pend);

   a_r10_active_xor_paused: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[0] && status[4]));

   a_r9_irq_with_end: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status[1]);

   a_r2_idle_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !status[0] |-> !mem_req_valid);

   a_r13_start_activates: assert property (@(posedge clk) disable iff (!rst_n)
      start && chan_en && !status[0] |=> status[0] && !irq);
endmodule

bind dma_chain_engine dma_chain_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_dma_chain_engine.sv
`timescale 1ns/100ps
module tb_dma_chain_engine;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chan_en = 1'b1;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          mem_req_valid, mem_req_write;
   logic          mem_req_ready = 1'b0;
   logic [AW-1:0] mem_req_addr;
   logic [31:0]   mem_req_wdata;
   logic          mem_rsp_valid = 1'b0;
   logic [31:0]   mem_rsp_rdata = '0;
   logic [4:0]    status;
   logic          irq;
   logic [31:0]   xfer_len;
   logic [AW-1:0] cur_desc;

   int total = 0;
   int bad = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int rdy_ph = 0;
   logic [31:0] mem [256];

   always #2.5 clk = ~clk;

   dma_chain_engine #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start(start), .start_addr(start_addr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .status(status), .irq(irq), .xfer_len(xfer_len), .cur_desc(cur_desc)
   );

   // memory model: ready stalls one cycle in three, read data one cycle after acceptance
   always @(negedge clk) begin
      rdy_ph = (rdy_ph + 1) % 3;
      mem_req_ready <= (rdy_ph != 0);
   end

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            mem[mem_req_addr[9:2]] = mem_req_wdata;
            wr_cnt = wr_cnt + 1;
         end else begin
            mem_rsp_rdata <= mem[mem_req_addr[9:2]];
            mem_rsp_valid <= 1'b1;
            rd_cnt = rd_cnt + 1;
         end
      end
   end

   function automatic logic [31:0] pat(input int byte_addr);
      return 32'hA500_0000 + 32'(byte_addr / 4);
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic fill();
      for (int i = 0; i < 256; i++) mem[i] = pat(i * 4);
   endtask

   task automatic put_desc(input int base, input logic [31:0] fl, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] ln,
                           input logic [31:0] sd, input logic [31:0] nx);
      mem[base/4]     = fl;
      mem[base/4 + 1] = s;
      mem[base/4 + 2] = d;
      mem[base/4 + 3] = ln;
      mem[base/4 + 4] = sd;
      mem[base/4 + 5] = nx;
   endtask

   int rd0, wr0;

   task automatic run(input logic [31:0] addr);
      rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      start_addr = addr;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 3000 && !status[4]; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R10 reset status", 32'(status), 32'h0);
      check("R9 reset irq", 32'(irq), 32'h0);
      check("R11 reset no request", 32'(mem_req_valid), 32'h0);
   endtask

   task automatic t_linear();
      fill();
      put_desc(32'h40, 32'h111, 32'h100, 32'h200, 32'd12, 32'h0, 32'h0);
      run(32'h40);
      check("R1 R4 linear word0", mem[32'h200/4], pat(32'h100));
      check("R4 linear word1", mem[32'h204/4], pat(32'h104));
      check("R4 linear word2", mem[32'h208/4], pat(32'h108));
      check("R4 linear no overrun", mem[32'h20C/4], pat(32'h20C));
      check("R9 linear status", 32'(status), 32'h16);
      check("R9 irq raised", 32'(irq), 32'h1);
      check("R7 linear final len", xfer_len, 32'h0);
      check("R9 next becomes current", cur_desc, 32'h0);
      check("R1 linear reads", 32'(rd_cnt - rd0), 32'd9);
      check("R4 linear writes", 32'(wr_cnt - wr0), 32'd3);
   endtask

   task automatic t_two_d();
      fill();
      put_desc(32'h40, 32'h112, 32'h100, 32'h200, 32'h0001_0008, 32'hFFF0_0008, 32'h0);
      run(32'h40);
      check("R3 row0 word0", mem[32'h200/4], pat(32'h100));
      check("R3 row0 word1", mem[32'h204/4], pat(32'h104));
      check("R8 row1 word0 neg stride", mem[32'h1F8/4], pat(32'h110));
      check("R8 row1 word1 neg stride", mem[32'h1FC/4], pat(32'h114));
      check("R3 untouched past row0", mem[32'h208/4], pat(32'h208));
      check("R13 R9 status no int", 32'(status), 32'h12);
      check("R13 irq cleared by start", 32'(irq), 32'h0);
      check("R7 2D final len", xfer_len, 32'h0001_0000);
      check("R3 2D writes", 32'(wr_cnt - wr0), 32'd4);
   endtask

   task automatic t_chain_fill();
      fill();
      put_desc(32'h40, 32'h110, 32'h100, 32'h240, 32'd4, 32'h0, 32'h60);
      put_desc(32'h60, 32'h811, 32'h100, 32'h250, 32'd8, 32'h0, 32'h0);
      run(32'h40);
      check("R2 chain first copy", mem[32'h240/4], pat(32'h100));
      check("R6 zero fill word0", mem[32'h250/4], 32'h0);
      check("R6 zero fill word1", mem[32'h254/4], 32'h0);
      check("R6 R2 chain reads", 32'(rd_cnt - rd0), 32'd13);
      check("R2 chain writes", 32'(wr_cnt - wr0), 32'd3);
      check("R9 chain status", 32'(status), 32'h16);
   endtask

   task automatic t_no_inc();
      fill();
      mem[32'h108/4] = 32'h1234_5678;
      put_desc(32'h40, 32'h000, 32'h108, 32'h260, 32'd12, 32'h0, 32'h0);
      run(32'h40);
      check("R5 fixed dst gets word", mem[32'h260/4], 32'h1234_5678);
      check("R5 fixed dst no advance", mem[32'h264/4], pat(32'h264));
      check("R5 fixed beats", 32'(wr_cnt - wr0), 32'd3);
   endtask

   task automatic t_skip_write();
      fill();
      put_desc(32'h40, 32'h190, 32'h100, 32'h270, 32'd8, 32'h0, 32'h0);
      run(32'h40);
      check("R6 write skipped count", 32'(wr_cnt - wr0), 32'd0);
      check("R6 reads still issued", 32'(rd_cnt - rd0), 32'd8);
      check("R6 dest untouched", mem[32'h270/4], pat(32'h270));
   endtask

   task automatic t_zero_len();
      fill();
      put_desc(32'h40, 32'h111, 32'h100, 32'h200, 32'd0, 32'h0, 32'h0);
      run(32'h40);
      check("R12 only fetch reads", 32'(rd_cnt - rd0), 32'd6);
      check("R12 no writes", 32'(wr_cnt - wr0), 32'd0);
      check("R12 completion flagged", 32'(status), 32'h16);
   endtask

   task automatic t_null_start();
      run(32'h0);
      check("R2 null start no access", 32'(rd_cnt - rd0), 32'd0);
      check("R10 R2 null start status", 32'(status), 32'h10);
   endtask

   task automatic t_disabled_start();
      chan_en = 1'b0;
      rd0 = rd_cnt;
      @(negedge clk);
      start_addr = 32'h40;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      check("R13 disabled start ignored", 32'(status), 32'h10);
      check("R13 disabled no access", 32'(rd_cnt - rd0), 32'd0);
      chan_en = 1'b1;
   endtask

   task automatic t_drop_enable();
      fill();
      put_desc(32'h40, 32'h110, 32'h100, 32'h280, 32'd8, 32'h0, 32'h60);
      put_desc(32'h60, 32'h110, 32'h100, 32'h290, 32'd4, 32'h0, 32'h0);
      @(negedge clk);
      start_addr = 32'h40;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chan_en = 1'b0;
      for (int i = 0; i < 3000 && !status[4]; i++) @(negedge clk);
      @(negedge clk);
      check("R2 current desc finishes", mem[32'h284/4], pat(32'h104));
      check("R2 second desc skipped", mem[32'h290/4], pat(32'h290));
      check("R2 stops at next pointer", cur_desc, 32'h60);
      check("R10 stopped status", 32'(status), 32'h12);
      chan_en = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      fill();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_linear();
      t_two_d();
      t_chain_fill();
      t_no_inc();
      t_skip_write();
      t_zero_len();
      t_null_start();
      t_disabled_start();
      t_drop_enable();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule